// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector under a one-bit-per-element mask. In compress mode the elements whose mask bit is set are gathered, in their original order, into the low positions of the result, and the number of gathered elements is reported. In expand mode the reverse happens: consecutive source elements, starting at element 0, are scattered into the positions whose mask bit is set, while unselected positions keep the prior destination contents supplied alongside the operands.

A caller presents the opcode, an active vector length, the mask, the source elements and the prior destination elements, and pulses start. The unit captures the operands and then walks the elements one per clock. A running pointer holds how many set mask bits have been seen so far. The result vector and the count are read when done is high, and they stay unchanged until the next accepted start. Elements and mask bits at or beyond the active length take no part in the operation.

Top module: `vmask_permute_unit`

## Requirements
- R1: With op_i = 0 (compress), the source elements at set mask positions appear in result element slots 0, 1, 2, ... in increasing source index order. Element k occupies bits [k*ELEM_W +: ELEM_W] of every element vector.
- R2: count_o equals the number of set mask bits below the effective length at done. It holds that value until the next accepted start, and it reads 0 in the cycle after acceptance.
- R3: With op_i = 1 (expand), the result slot at the j-th set mask position (j counted from 0) receives source element j.
- R4: With op_i = 1, every result slot whose mask bit is 0 equals the prior destination element.
- R5: With op_i = 0, every result slot at or above the final count equals the prior destination element.
- R6: One element is processed per clock. The result visible j edges after the accepting edge reflects exactly elements 0..j-1. done_o is high for exactly one cycle, L edges after the accepting edge, where L is the effective length (in the cycle right after acceptance when L = 0). busy_o is high from acceptance until done_o and is never high together with done_o.
- R7: The effective length L is min(vl_i, MAX_VL). Mask bits and source elements at index L or above have no effect on the result or the count.
- R8: An all-zero mask gives count 0 and a result equal to the prior destination, for both opcodes.
- R9: A start pulse while busy_o is high is ignored: the operation in flight completes with its captured operands and its original timing.
- R10: After a synchronous active-low reset, busy_o, done_o, count_o and result_o are all 0. While the unit is idle and no start is accepted, result_o and count_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when not busy) |
| op_i | input | 1 | 0 = compress, 1 = expand |
| vl_i | input | CNT_W | Requested vector length (clamped to MAX_VL) |
| mask_i | input | MAX_VL | One mask bit per element |
| src_i | input | MAX_VL*ELEM_W | Source element vector |
| dst_old_i | input | MAX_VL*ELEM_W | Prior destination element vector |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | CNT_W | Number of set mask bits processed |
| result_o | output | MAX_VL*ELEM_W | Result element vector |

## Verification
The hardest situation to reach from the ports is a start pulse arriving while an operation is in flight: it must be timed to land between acceptance and the last element, and its operands must differ from those being processed. The bench drives such a pulse with fresh opcode, mask and data one cycle after acceptance on a long operation. Its per-cycle model then shows any leak, in either the partial results or the completion timing. Lengths above the maximum and short lengths with mask bits set beyond them are driven alongside, so that ignored tail bits would change the count visibly.

// File: rtl/vmpu_pkg.sv
// Package: shared opcode type for the mask compress/expand unit.
// Assumes: the opcode input is one bit wide.
package vmpu_pkg;

    typedef enum logic {
        OP_COMPRESS = 1'b0,
        OP_EXPAND   = 1'b1
    } vmpu_op_e;

endpackage

// File: rtl/vmpu_ctrl.sv
// Module: vmpu_ctrl
// Sequencer. It accepts a start when idle, captures the opcode, the mask and the
// clamped length, then steps an element index once per cycle and pulses done
// after the last element.
// Assumes: MAX_VL >= 2; the datapath and the pointer act on step_o.
module vmpu_ctrl
    import vmpu_pkg::*;
#(
    parameter int MAX_VL = 8,
    localparam int CNT_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [CNT_W-1:0]  vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    output logic              accept_o,
    output logic              step_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic              cur_bit_o,
    output vmpu_op_e          op_o,
    output logic              busy_o,
    output logic              done_o
);

    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  idx_q;
    logic [MAX_VL-1:0] mask_q;
    logic [CNT_W-1:0]  eff_len;
    logic              last_step;
    vmpu_op_e          op_q;

    // Clamp the requested length to the element count.
    always_comb begin
        eff_len = (vl_i > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vl_i;
    end

    // Pick the mask bit of the element under the index.
    always_comb begin
        cur_bit_o = 1'b0;
        for (int k = 0; k < MAX_VL; k++) begin
            if (idx_q == CNT_W'(k)) cur_bit_o = mask_q[k];
        end
    end

    assign accept_o  = start_i && !busy_o;
    assign step_o    = busy_o;
    assign last_step = busy_o && ((idx_q + CNT_W'(1)) == len_q);
    assign idx_o     = idx_q;
    assign op_o      = op_q;

    // Capture operands on acceptance and advance the index while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            idx_q  <= '0;
            len_q  <= '0;
            mask_q <= '0;
            op_q   <= OP_COMPRESS;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                op_q   <= vmpu_op_e'(op_i);
                mask_q <= mask_i;
                len_q  <= eff_len;
                idx_q  <= '0;
                if (eff_len == '0) done_o <= 1'b1;
                else               busy_o <= 1'b1;
            end else if (last_step) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
            end else if (busy_o) begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R6
    last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_step |=> (done_o && !busy_o));

    // R6
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (idx_q < len_q));

endmodule

// File: rtl/vmpu_ptr.sv
// Module: vmpu_ptr
// Packed-position pointer. It counts the set mask bits met so far; the count is
// the compress write slot, the expand read slot and the reported length.
// Assumes: the sequencer clears it through accept_i before the first step.
module vmpu_ptr #(
    parameter int MAX_VL = 8,
    localparam int CNT_W = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             step_i,
    input  logic             cur_bit_i,
    input  logic [CNT_W-1:0] idx_i,
    output logic [CNT_W-1:0] ptr_o
);

    // Clear on acceptance and count set bits as elements are stepped.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ptr_o <= '0;
        else if (accept_i)               ptr_o <= '0;
        else if (step_i && cur_bit_i)    ptr_o <= ptr_o + CNT_W'(1);
    end

    // R2
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (ptr_o <= idx_i));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !accept_i) |=> $stable(ptr_o));

endmodule

// File: rtl/vmpu_datapath.sv
// Module: vmpu_datapath
// Element storage. It loads the prior destination on acceptance and writes one
// element per step: compress writes slot ptr from source idx, expand writes slot
// idx from source ptr, and both write only when the current mask bit is set.
// Assumes: ptr_i <= idx_i < MAX_VL whenever step_i is high.
module vmpu_datapath
    import vmpu_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int ELEM_W = 32,
    localparam int CNT_W = $clog2(MAX_VL + 1),
    localparam int VEC_W = MAX_VL * ELEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             step_i,
    input  logic             cur_bit_i,
    input  vmpu_op_e         op_i,
    input  logic [CNT_W-1:0] idx_i,
    input  logic [CNT_W-1:0] ptr_i,
    input  logic [VEC_W-1:0] src_i,
    input  logic [VEC_W-1:0] dst_old_i,
    output logic [VEC_W-1:0] result_o
);

    logic [ELEM_W-1:0] src_q [MAX_VL];
    logic [ELEM_W-1:0] wr_data;
    logic [CNT_W-1:0]  rd_sel;
    logic [CNT_W-1:0]  wr_sel;

    // Expand reads at the pointer and writes at the index; compress swaps them.
    always_comb begin
        rd_sel = (op_i == OP_EXPAND) ? ptr_i : idx_i;
        wr_sel = (op_i == OP_EXPAND) ? idx_i : ptr_i;
    end

    // Select the source element addressed by rd_sel.
    always_comb begin
        wr_data = '0;
        for (int k = 0; k < MAX_VL; k++) begin
            if (rd_sel == CNT_W'(k)) wr_data = src_q[k];
        end
    end

    // Hold a private copy of the source so later input changes do not leak in.
    always_ff @(posedge clk) begin
        if (accept_i) begin
            for (int k = 0; k < MAX_VL; k++) src_q[k] <= src_i[k*ELEM_W +: ELEM_W];
        end
    end

    for (genvar g = 0; g < MAX_VL; g++) begin : g_slot
        logic wr_en;
        assign wr_en = step_i && cur_bit_i && (wr_sel == CNT_W'(g));

        // Per-slot register: reset, prior-destination load, or masked write.
        always_ff @(posedge clk) begin
            if (!rst_n)        result_o[g*ELEM_W +: ELEM_W] <= '0;
            else if (accept_i) result_o[g*ELEM_W +: ELEM_W] <= dst_old_i[g*ELEM_W +: ELEM_W];
            else if (wr_en)    result_o[g*ELEM_W +: ELEM_W] <= wr_data;
        end

        // R4
        expand_clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step_i && op_i == OP_EXPAND && idx_i == CNT_W'(g) && !cur_bit_i)
            |=> $stable(result_o[g*ELEM_W +: ELEM_W]));
    end

endmodule

// File: rtl/vmask_permute_unit.sv
// Module: vmask_permute_unit (top)
// Mask-driven compress/expand over one vector of MAX_VL elements, one element
// per clock. It ties the sequencer, the packed-position pointer and the element
// storage together.
// Assumes: MAX_VL >= 2; op_i 0 = compress, 1 = expand.
module vmask_permute_unit
    import vmpu_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int ELEM_W = 32,
    localparam int CNT_W = $clog2(MAX_VL + 1),
    localparam int VEC_W = MAX_VL * ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [CNT_W-1:0]  vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [VEC_W-1:0]  src_i,
    input  logic [VEC_W-1:0]  dst_old_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [VEC_W-1:0]  result_o
);

    logic             accept;
    logic             step;
    logic             cur_bit;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] ptr;
    vmpu_op_e         op_cur;

    vmpu_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .vl_i      (vl_i),
        .mask_i    (mask_i),
        .accept_o  (accept),
        .step_o    (step),
        .idx_o     (idx),
        .cur_bit_o (cur_bit),
        .op_o      (op_cur),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    vmpu_ptr #(.MAX_VL(MAX_VL)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .step_i    (step),
        .cur_bit_i (cur_bit),
        .idx_i     (idx),
        .ptr_o     (ptr)
    );

    vmpu_datapath #(.MAX_VL(MAX_VL), .ELEM_W(ELEM_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .step_i    (step),
        .cur_bit_i (cur_bit),
        .op_i      (op_cur),
        .idx_i     (idx),
        .ptr_i     (ptr),
        .src_i     (src_i),
        .dst_old_i (dst_old_i),
        .result_o  (result_o)
    );

    assign count_o = ptr;

    // R10
    idle_result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(start_i && !busy_o)) |=> $stable(result_o));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(count_o));

endmodule

// File: tb/vmask_permute_unit_tb.sv
module vmask_permute_unit_tb;

    localparam int VLM = 8;
    localparam int EW  = 32;
    localparam int CW  = $clog2(VLM + 1);
    localparam int VW  = VLM * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic [CW-1:0] vl_i = '0;
    logic [VLM-1:0] mask_i = '0;
    logic [VW-1:0] src_i = '0;
    logic [VW-1:0] dst_old_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [CW-1:0] count_o;
    logic [VW-1:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vmask_permute_unit #(.MAX_VL(VLM), .ELEM_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .vl_i(vl_i),
        .mask_i(mask_i), .src_i(src_i), .dst_old_i(dst_old_i),
        .busy_o(busy_o), .done_o(done_o), .count_o(count_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: outcome after the first n elements are processed.
    function automatic logic [VW-1:0] ref_res(bit op, logic [VLM-1:0] m,
            logic [VW-1:0] s, logic [VW-1:0] d, int n);
        logic [VW-1:0] r = d;
        int p = 0;
        for (int k = 0; k < n; k++) begin
            if (m[k]) begin
                if (!op) r[p*EW +: EW] = s[k*EW +: EW];
                else     r[k*EW +: EW] = s[p*EW +: EW];
                p++;
            end
        end
        return r;
    endfunction

    function automatic int ref_cnt(logic [VLM-1:0] m, int n);
        int c = 0;
        for (int k = 0; k < n; k++) if (m[k]) c++;
        return c;
    endfunction

    // Run one operation and compare against the model on every clock.
    task automatic run_op(input bit op, input int vl, input logic [VLM-1:0] m,
                          input logic [VW-1:0] s, input logic [VW-1:0] d,
                          input bit poke_busy, input string req);
        int len;
        len = (vl > VLM) ? VLM : vl;
        @(negedge clk);
        start_i = 1'b1; op_i = op; vl_i = CW'(vl); mask_i = m; src_i = s; dst_old_i = d;
        @(negedge clk);
        start_i = 1'b0;
        // Scramble inputs after capture: captured operands must be used.
        src_i = ~s; mask_i = ~m; dst_old_i = ~d; op_i = ~op; vl_i = CW'(1);
        for (int j = 0; j <= len; j++) begin
            chk(result_o == ref_res(op, m, s, d, j), req, $sformatf("result step %0d", j),
                result_o, ref_res(op, m, s, d, j));
            chk(int'(count_o) == ref_cnt(m, j), "R2", $sformatf("count step %0d", j),
                VW'(count_o), VW'(ref_cnt(m, j)));
            chk(done_o == (j == len), "R6", $sformatf("done step %0d", j),
                VW'(done_o), VW'(j == len));
            chk(busy_o == (j < len), "R6", $sformatf("busy step %0d", j),
                VW'(busy_o), VW'(j < len));
            if (poke_busy && j == 1) start_i = 1'b1;  // R9: start while busy
            else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(done_o == 1'b0, "R6", "done single pulse", VW'(done_o), '0);
        chk(result_o == ref_res(op, m, s, d, len), "R10", "idle hold result",
            result_o, ref_res(op, m, s, d, len));
        chk(int'(count_o) == ref_cnt(m, len), "R2", "count held",
            VW'(count_o), VW'(ref_cnt(m, len)));
    endtask

    function automatic logic [VW-1:0] pat(int base);
        logic [VW-1:0] v;
        for (int k = 0; k < VLM; k++) v[k*EW +: EW] = EW'(base + k * 17 + 1);
        return v;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(busy_o == 1'b0 && done_o == 1'b0, "R10", "reset busy/done",
            VW'({busy_o, done_o}), '0);
        chk(count_o == '0, "R10", "reset count", VW'(count_o), '0);
        chk(result_o == '0, "R10", "reset result", result_o, '0);

        // R1/R5 compress with scattered mask
        run_op(1'b0, 8, 8'b1011_0010, pat(100), pat(5000), 1'b0, "R1");
        // R3/R4 expand
        run_op(1'b1, 8, 8'b0110_1001, pat(200), pat(6000), 1'b0, "R3");
        // R1 compress full mask
        run_op(1'b0, 8, 8'hFF, pat(300), pat(7000), 1'b0, "R1");
        // R4 expand sparse mask: most slots keep old data
        run_op(1'b1, 8, 8'b1000_0000, pat(400), pat(8000), 1'b0, "R4");
        // R5 compress with few bits: high slots keep old data
        run_op(1'b0, 8, 8'b0100_0100, pat(450), pat(8500), 1'b0, "R5");
        // R8 all-zero mask, both opcodes
        run_op(1'b0, 8, 8'h00, pat(500), pat(9000), 1'b0, "R8");
        run_op(1'b1, 8, 8'h00, pat(600), pat(9500), 1'b0, "R8");
        // R7 short length with tail bits set, and length above maximum
        run_op(1'b0, 3, 8'b1111_0101, pat(700), pat(10000), 1'b0, "R7");
        run_op(1'b1, 5, 8'b1110_1010, pat(800), pat(11000), 1'b0, "R7");
        run_op(1'b0, 13, 8'b1001_0110, pat(900), pat(12000), 1'b0, "R7");
        // R6 zero length: done in the cycle after acceptance
        run_op(1'b1, 0, 8'hFF, pat(950), pat(12500), 1'b0, "R6");
        // R9 start pulse while busy is ignored
        run_op(1'b0, 8, 8'b1100_1010, pat(1000), pat(13000), 1'b1, "R9");
        run_op(1'b1, 8, 8'b0011_0101, pat(1100), pat(14000), 1'b1, "R9");

        // R10 idle hold across several cycles with inputs toggling
        mask_i = 8'hA5; src_i = pat(1234); dst_old_i = pat(4321);
        repeat (3) @(negedge clk);
        chk(result_o == ref_res(1'b1, 8'b0011_0101, pat(1100), pat(14000), 8), "R10",
            "idle hold long", result_o,
            ref_res(1'b1, 8'b0011_0101, pat(1100), pat(14000), 8));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule